// File: doc/BRIEF.md
# Split-Readout Cycle Counter with Tear Detection

A free-running cycle counter twice as wide as the register data path. Software reads it as two halves: first the lower half, then the upper half, then the control word. The control word's top bit is a status flag. It reads 1 only if the two halves just read belong to the same counter value. If the flag is 0, software repeats the three reads.

A small tracker inside the block follows each lower-then-upper read pair. Two events mark the pair as torn:
- a carry out of the lower half while the pair is open;
- an exception or interrupt, signalled on a one-cycle event input, while the pair is open.

Only a pair that is opened, then closed by an upper-half read with neither event in between, raises the flag. Bit 0 of the control word enables counting. The counter starts at zero after reset and holds its value while disabled.

Top module: `tear_counter64`

## Requirements
- R1: After reset the counter is 0, counting is disabled, the status flag is 0 and the read data output is 0.
- R2: A write to the control address (0x103) loads bit 0 of the write data into the enable bit. While the enable bit is 0 the counter keeps its value.
- R3: While enabled, the counter advances by one every clock cycle. A read of address 0x104 returns the lower DATA_W bits and a read of 0x105 returns the upper DATA_W bits. Read data appears on the output in the cycle after the read request and holds until the next read.
- R4: A read of 0x103 returns the enable bit in bit 0 and the status flag in bit DATA_W-1 (bit 31 at the default width), with zeros elsewhere. The flag becomes 1 only through an upper-half read that closes an undisturbed pair.
- R5: The pair is torn if, in any cycle from the lower-half read up to the cycle before the upper-half read, the counter is enabled with its lower half all ones. A carry in the upper-half read cycle itself does not tear the pair.
- R6: The pair is torn if the event input is high in any cycle from the lower-half read up to the cycle before the upper-half read. The event input in the upper-half read cycle itself is not counted.
- R7: An upper-half read with no open pair sets the status flag to 0. Each upper-half read closes the pair, so a second upper-half read always sets the flag to 0.
- R8: A lower-half read clears the status flag to 0, discards any earlier tear and opens a fresh pair, so that a retry can succeed.
- R9: Writes to 0x104, 0x105 or any address other than 0x103 change neither the counter nor the status flag.
- R10: A read of an address outside 0x103 to 0x105 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register address |
| regRdEn | input | 1 | Read request for regAddr, one cycle per read |
| regWrEn | input | 1 | Write request for regAddr |
| regWrData | input | DATA_W | Write data; only bit 0 is used, at the control address |
| excEvent | input | 1 | High for each cycle in which an exception or interrupt is taken |
| rdData | output | DATA_W | Registered read data, valid the cycle after a read |

## Verification
The properties assume that every input is synchronous to the clock and holds known values from reset onward. They also assume one address per request, so a single cycle never reads two registers. The carry and event properties cover only the closest cases: a carry in the cycle of a lower-half read that is followed at once by an upper-half read, and an event exactly one cycle before the upper-half read. The bench drives all inputs on the falling edge and instantiates the block with an 8-bit data path, so the lower half wraps every 256 cycles. It waits for chosen lower-half values to place carries exactly at, just before and just after the edges of a read pair.

// File: rtl/tear_cnt_pkg.sv
package tear_cnt_pkg;

  // Decoded register accesses, one strobe per access kind
  typedef struct packed {
    logic loRd;
    logic hiRd;
    logic ctrlRd;
    logic ctrlWr;
    logic anyRd;
  } regStrobe_t;

  // Pair tracker: no open pair, open and clean, open and torn
  typedef enum logic [1:0] {
    TRK_IDLE  = 2'd0,
    TRK_ARMED = 2'd1,
    TRK_TORN  = 2'd2
  } trkState_t;

endpackage

// File: rtl/tear_track.sv
module tear_track
  import tear_cnt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h103),
  parameter logic [ADDR_W-1:0] LO_ADDR   = ADDR_W'('h104),
  parameter logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'('h105)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic              excEvent,
  input  logic              carryIn,
  output regStrobe_t        strobes,
  output logic              pairOk
);

  trkState_t trkState;
  logic      disturb;

  always_comb begin
    strobes.loRd   = regRdEn && (regAddr == LO_ADDR);
    strobes.hiRd   = regRdEn && (regAddr == HI_ADDR);
    strobes.ctrlRd = regRdEn && (regAddr == CTRL_ADDR);
    strobes.ctrlWr = regWrEn && (regAddr == CTRL_ADDR);
    strobes.anyRd  = regRdEn;
  end

  // A carry or an exception taken while a pair is open tears it (R5, R6)
  assign disturb = carryIn || excEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trkState <= TRK_IDLE;
      pairOk   <= 1'b0;
    end else if (strobes.loRd) begin
      // R8: new pair, earlier tear forgotten
      trkState <= disturb ? TRK_TORN : TRK_ARMED;
      pairOk   <= 1'b0;
    end else if (strobes.hiRd) begin
      // R4, R7: close the pair; events in this cycle do not count
      pairOk   <= (trkState == TRK_ARMED);
      trkState <= TRK_IDLE;
    end else if ((trkState == TRK_ARMED) && disturb) begin
      trkState <= TRK_TORN;
    end
  end

endmodule

// File: rtl/tear_dpath.sv
module tear_dpath
  import tear_cnt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobes,
  input  logic              wrEnBit,
  input  logic              pairOk,
  output logic              carryOut,
  output logic [CNT_W-1:0]  countNow,
  output logic              counterOn,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] ctrlWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) counterOn <= 1'b0;
    else if (strobes.ctrlWr) counterOn <= wrEnBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) countNow <= '0;
    else if (counterOn) countNow <= countNow + CNT_W'(1);
  end

  // The upper half changes at the next edge
  assign carryOut = counterOn && (&countNow[DATA_W-1:0]);

  assign ctrlWord = {pairOk, {(DATA_W-2){1'b0}}, counterOn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else if (strobes.anyRd) begin
      if (strobes.loRd)        rdData <= countNow[DATA_W-1:0];
      else if (strobes.hiRd)   rdData <= countNow[CNT_W-1:DATA_W];
      else if (strobes.ctrlRd) rdData <= ctrlWord;
      else                     rdData <= '0;
    end
  end

endmodule

// File: rtl/tear_counter64.sv
module tear_counter64
  import tear_cnt_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'('h103),
  parameter logic [ADDR_W-1:0] LO_ADDR   = ADDR_W'('h104),
  parameter logic [ADDR_W-1:0] HI_ADDR   = ADDR_W'('h105)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regRdEn,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              excEvent,
  output logic [DATA_W-1:0] rdData
);

  localparam int unsigned CNT_W = 2 * DATA_W;

  regStrobe_t       strobes;
  logic             pairOk;
  logic             carryOut;
  logic             counterOn;
  logic [CNT_W-1:0] countNow;
  logic             unusedWrBits;

  assign unusedWrBits = ^regWrData[DATA_W-1:1];

  tear_track #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
  ) u_track (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .excEvent(excEvent), .carryIn(carryOut),
    .strobes(strobes), .pairOk(pairOk)
  );

  tear_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrEnBit(regWrData[0]),
    .pairOk(pairOk), .carryOut(carryOut), .countNow(countNow),
    .counterOn(counterOn), .rdData(rdData)
  );

endmodule

// File: rtl/tear_cnt_chk.sv
module tear_cnt_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'('h104),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'('h105),
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              excEvent,
  input logic [DATA_W-1:0] rdData,
  input logic [CNT_W-1:0]  countNow,
  input logic              counterOn,
  input logic              pairOk
);

  logic loRd, hiRd;
  assign loRd = regRdEn && (regAddr == LO_ADDR);
  assign hiRd = regRdEn && (regAddr == HI_ADDR);

  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !counterOn |=> $stable(countNow));

  p_step_on_r3: assert property (@(posedge clk) disable iff (!rstN)
    counterOn |=> countNow == $past(countNow) + CNT_W'(1));

  p_lo_data_r3: assert property (@(posedge clk) disable iff (!rstN)
    loRd |=> rdData == $past(countNow[DATA_W-1:0]));

  p_rise_on_hi_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pairOk) |-> $past(hiRd));

  p_carry_torn_r5: assert property (@(posedge clk) disable iff (!rstN)
    (hiRd && $past(loRd) && $past(counterOn) && (&$past(countNow[DATA_W-1:0])))
    |=> !pairOk);

  p_exc_torn_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hiRd && $past(excEvent) && $past(loRd, 2)) |=> !pairOk);

  p_hi_twice_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hiRd && $past(hiRd)) |=> !pairOk);

  p_lo_clears_r8: assert property (@(posedge clk) disable iff (!rstN)
    loRd |=> !pairOk);

endmodule

bind tear_counter64 tear_cnt_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .regRdEn(regRdEn), .regAddr(regAddr),
  .excEvent(excEvent), .rdData(rdData), .countNow(countNow),
  .counterOn(counterOn), .pairOk(pairOk)
);

// File: tb/sim_tear_counter64.sv
module sim_tear_counter64;

  localparam int DW = 8;
  localparam logic [11:0] A_CTRL = 12'h103;
  localparam logic [11:0] A_LO   = 12'h104;
  localparam logic [11:0] A_HI   = 12'h105;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   regAddr = '0;
  logic          regRdEn = 1'b0;
  logic          regWrEn = 1'b0;
  logic [DW-1:0] regWrData = '0;
  logic          excEvent = 1'b0;
  logic [DW-1:0] rdData;

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int enEdge = 0;
  logic done = 1'b0;

  tear_counter64 #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdEn(regRdEn),
    .regWrEn(regWrEn), .regWrData(regWrData), .excEvent(excEvent),
    .rdData(rdData)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge
  task automatic doRead(input logic [11:0] a, output logic [DW-1:0] v);
    regAddr = a; regRdEn = 1'b1;
    @(negedge clk);
    regRdEn = 1'b0;
    v = rdData;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [DW-1:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counter value sampled by the read at rising edge e
  function automatic logic [2*DW-1:0] modelAt(input int e);
    return (2*DW)'(e - enEdge - 1);
  endfunction

  task automatic waitLow(input logic [DW-1:0] target);
    while (DW'(cyc - enEdge) != target) @(negedge clk);
  endtask

  task automatic readPair(output logic [DW-1:0] lo, output logic [DW-1:0] hi,
                          output logic [DW-1:0] ctl, output int eLo);
    eLo = cyc + 1;
    doRead(A_LO, lo);
    doRead(A_HI, hi);
    doRead(A_CTRL, ctl);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    check("R1 rdData after reset", 32'(rdData), 0);
    doRead(A_CTRL, v); check("R1 ctrl after reset", 32'(v), 0);
    doRead(A_LO, v);   check("R1 low after reset", 32'(v), 0);
    doRead(A_HI, v);   check("R1 high after reset", 32'(v), 0);
  endtask

  task automatic t_disabled();
    logic [DW-1:0] v;
    idle(20);
    doRead(A_LO, v); check("R2 held while disabled", 32'(v), 0);
  endtask

  task automatic t_enable();
    logic [DW-1:0] lo, hi, ctl;
    int e;
    enEdge = cyc + 1;
    doWrite(A_CTRL, 8'h01);
    idle(5);
    readPair(lo, hi, ctl, e);
    check("R3 low value", 32'(lo), 32'(modelAt(e)[DW-1:0]));
    check("R3 high value", 32'(hi), 32'(modelAt(e+1)[2*DW-1:DW]));
    check("R4 ctrl enabled and consistent", 32'(ctl), 32'h81);
  endtask

  task automatic t_carry();
    logic [DW-1:0] lo, hi, ctl;
    int e;
    waitLow(8'hFF);
    readPair(lo, hi, ctl, e);
    check("R5 low at all ones", 32'(lo), 32'hFF);
    check("R5 high after carry", 32'(hi), 32'(modelAt(e+1)[2*DW-1:DW]));
    check("R5 carry between reads tears", 32'(ctl[DW-1]), 0);
    waitLow(8'hFE);
    readPair(lo, hi, ctl, e);
    check("R5 carry in high cycle is clean", 32'(ctl[DW-1]), 1);
    waitLow(8'hFD);
    doRead(A_LO, lo);
    idle(3);
    doRead(A_HI, hi);
    doRead(A_CTRL, ctl);
    check("R5 carry in gap tears", 32'(ctl[DW-1]), 0);
  endtask

  task automatic t_exc();
    logic [DW-1:0] lo, hi, ctl;
    waitLow(8'h10);
    doRead(A_LO, lo);
    excEvent = 1'b1; idle(1); excEvent = 1'b0;
    doRead(A_HI, hi);
    doRead(A_CTRL, ctl);
    check("R6 exception between reads tears", 32'(ctl[DW-1]), 0);
    waitLow(8'h40);
    doRead(A_LO, lo);
    excEvent = 1'b1; doRead(A_HI, hi); excEvent = 1'b0;
    doRead(A_CTRL, ctl);
    check("R6 exception in high cycle ignored", 32'(ctl[DW-1]), 1);
  endtask

  task automatic t_retry();
    logic [DW-1:0] lo, hi, ctl;
    int e;
    waitLow(8'h20);
    doRead(A_LO, lo);
    excEvent = 1'b1; idle(1); excEvent = 1'b0;
    readPair(lo, hi, ctl, e);
    check("R8 retry after tear is consistent", 32'(ctl[DW-1]), 1);
    doRead(A_LO, lo);
    doRead(A_CTRL, ctl);
    check("R8 low read clears status", 32'(ctl[DW-1]), 0);
  endtask

  task automatic t_hiAlone();
    logic [DW-1:0] lo, hi, ctl;
    int e;
    waitLow(8'h30);
    readPair(lo, hi, ctl, e);
    doRead(A_HI, hi);
    doRead(A_CTRL, ctl);
    check("R7 high read without low gives 0", 32'(ctl[DW-1]), 0);
  endtask

  task automatic t_writes();
    logic [DW-1:0] lo, hi, ctl;
    int e;
    waitLow(8'h50);
    readPair(lo, hi, ctl, e);
    doWrite(A_LO, 8'hAA);
    doWrite(A_HI, 8'h55);
    doWrite(12'h2F0, 8'h00);
    doRead(A_CTRL, ctl);
    check("R9 writes keep status and enable", 32'(ctl), 32'h81);
    e = cyc + 1;
    doRead(A_LO, lo);
    check("R9 writes keep counter", 32'(lo), 32'(modelAt(e)[DW-1:0]));
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] v;
    doRead(12'h200, v);
    check("R10 unmapped read is zero", 32'(v), 0);
  endtask

  task automatic t_disable();
    logic [DW-1:0] a, b, ctl;
    doWrite(A_CTRL, 8'h00);
    doRead(A_LO, a);
    idle(10);
    doRead(A_LO, b);
    check("R2 count holds after disable", 32'(b), 32'(a));
    doRead(A_CTRL, ctl);
    check("R2 enable bit cleared", 32'(ctl[0]), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_enable();
    t_carry();
    t_exc();
    t_retry();
    t_hiAlone();
    t_writes();
    t_unmapped();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1'b1;
      checks++; errs++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule